// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A bank of 32 general-purpose pins, reached through a small byte-addressed register space with single-cycle read and write strobes. Software sets the level each pin drives through an output latch and picks, pin by pin, whether the pin drives or only listens. Every pin's input passes through a two-flop synchronizer. The value register returns that synchronized level, even for pins that are driving. Because of this, a second, read-only register is provided to return the output latch exactly.

Each pin can raise an interrupt. Three mode registers select the event type for each pin: falling edge, rising edge, both edges, active-low level or active-high level. A detected event sets a sticky status bit. Writing a 1 to a status bit clears that bit. A per-pin enable mask decides which status bits drive the single, registered interrupt output. Edge detection compares the synchronized sample of the current cycle with the sample of the cycle before.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output latch, direction, enable, the three mode registers and status all read 0, and `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to offset 0x00 loads the output latch, which drives `pin_out` from the next cycle. Offset 0x1C returns the latch exactly. Writes to 0x1C are ignored.
- R3: A read of offset 0x00 returns `pin_in` after two synchronizer stages, whatever the pin's direction. A read issued in the cycle after an input change still returns the old level.
- R4: Offset 0x04 is the direction register. A bit of 1 makes that pin an output: `pin_oe` carries the register contents.
- R5: The mode registers are sel_a at 0x0C, sel_b at 0x10 and sel_c at 0x14, with one bit per pin (bit n is pin n). When sel_b=0, sel_c=0 and sel_a=1, a rising edge of the synchronized input sets the pin's status bit. A falling edge then has no effect.
- R6: When sel_b=0, sel_c=0 and sel_a=0, a falling edge sets the status bit. A rising edge has no effect.
- R7: When sel_b=0 and sel_c=1, either edge sets the status bit, whatever the value of sel_a.
- R8: When sel_b=1, the pin is level-sensitive. sel_a=1 means active high and sel_a=0 means active low. The status bit stays set for as long as the level is active, even across a clear.
- R9: Status is at 0x18. Writing a 1 clears that edge-mode bit. Bits written as 0 keep their state. A status bit set in edge mode holds until it is cleared.
- R10: The enable mask is at 0x08. `irq` is the registered OR of status AND enable over all pins. Status bits are still set while their pin is disabled.
- R11: Read data is registered and is valid the cycle after `rd_en`. An offset outside the map reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Output latch contents |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `wr_en` and `rd_en` are never raised together. They also assume that every strobe is exactly one cycle long with a stable address. Finally, they assume that `pin_in` settles away from the clock edge, so that the synchronizer carries clean levels.

The bench changes pins and strobes only on falling clock edges and issues one access at a time. It waits at least four cycles after a pin change before it reads status or samples `irq`. The one exception is the read that deliberately probes the synchronizer delay.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFF_VALUE  = 8'h00;
  localparam logic [7:0] OFF_DIR    = 8'h04;
  localparam logic [7:0] OFF_IRQ_EN = 8'h08;
  localparam logic [7:0] OFF_SEL_A  = 8'h0C;
  localparam logic [7:0] OFF_SEL_B  = 8'h10;
  localparam logic [7:0] OFF_SEL_C  = 8'h14;
  localparam logic [7:0] OFF_STATUS = 8'h18;
  localparam logic [7:0] OFF_LATCH  = 8'h1C;

  typedef enum logic [2:0] {
    DET_FALL,
    DET_RISE,
    DET_BOTH,
    DET_LVL_LO,
    DET_LVL_HI
  } det_mode_e;

  function automatic det_mode_e decode_mode(input logic sel_a, input logic sel_b,
                                            input logic sel_c);
    if (sel_b)      return sel_a ? DET_LVL_HI : DET_LVL_LO;
    else if (sel_c) return DET_BOTH;
    else            return sel_a ? DET_RISE : DET_FALL;
  endfunction

  function automatic logic detect_hit(input det_mode_e mode, input logic cur,
                                      input logic prev);
    case (mode)
      DET_RISE:   return cur & ~prev;
      DET_FALL:   return ~cur & prev;
      DET_BOTH:   return cur ^ prev;
      DET_LVL_HI: return cur;
      DET_LVL_LO: return ~cur;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= async_in;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] smp,
  input  logic [NPINS-1:0] sel_a,
  input  logic [NPINS-1:0] sel_b,
  input  logic [NPINS-1:0] sel_c,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= smp;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    det_mode_e mode;
    always_comb begin
      mode   = decode_mode(sel_a[i], sel_b[i], sel_c[i]);
      hit[i] = detect_hit(mode, smp[i], prev_q[i]);
    end

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= (status_q[i] & ~clr[i]) | hit[i];
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  input  logic [NPINS-1:0] smp,
  input  logic [NPINS-1:0] status,
  output logic [NPINS-1:0] rdata,
  output logic [NPINS-1:0] latch,
  output logic [NPINS-1:0] dir,
  output logic [NPINS-1:0] irq_en,
  output logic [NPINS-1:0] sel_a,
  output logic [NPINS-1:0] sel_b,
  output logic [NPINS-1:0] sel_c,
  output logic [NPINS-1:0] clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch  <= '0;
      dir    <= '0;
      irq_en <= '0;
      sel_a  <= '0;
      sel_b  <= '0;
      sel_c  <= '0;
    end else if (wr_en) begin
      case (addr)
        AW'(OFF_VALUE):  latch  <= wdata;
        AW'(OFF_DIR):    dir    <= wdata;
        AW'(OFF_IRQ_EN): irq_en <= wdata;
        AW'(OFF_SEL_A):  sel_a  <= wdata;
        AW'(OFF_SEL_B):  sel_b  <= wdata;
        AW'(OFF_SEL_C):  sel_c  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr = '0;
    if (wr_en && addr == AW'(OFF_STATUS)) clr = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        AW'(OFF_VALUE):  rdata <= smp;
        AW'(OFF_DIR):    rdata <= dir;
        AW'(OFF_IRQ_EN): rdata <= irq_en;
        AW'(OFF_SEL_A):  rdata <= sel_a;
        AW'(OFF_SEL_B):  rdata <= sel_b;
        AW'(OFF_SEL_C):  rdata <= sel_c;
        AW'(OFF_STATUS): rdata <= status;
        AW'(OFF_LATCH):  rdata <= latch;
        default:         rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS       = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [NPINS-1:0] smp, status, latch, dir, irq_en;
  logic [NPINS-1:0] sel_a, sel_b, sel_c, clr;
  logic             irq_q;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(smp)
  );

  gpio_regfile #(.NPINS(NPINS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .smp(smp), .status(status), .rdata(rdata),
    .latch(latch), .dir(dir), .irq_en(irq_en), .sel_a(sel_a),
    .sel_b(sel_b), .sel_c(sel_c), .clr(clr)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .smp(smp), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .clr(clr), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & irq_en);
  end

  assign pin_out = latch;
  assign pin_oe  = dir;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [NPINS-1:0] wdata,
  input logic [NPINS-1:0] rdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] smp,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] irq_en,
  input logic [NPINS-1:0] sel_a,
  input logic [NPINS-1:0] sel_b
);
  logic [NPINS-1:0] clr_mask;
  logic             mapped;
  assign clr_mask = (wr_en && addr == AW'(OFF_STATUS)) ? wdata : '0;
  assign mapped = addr inside {AW'(OFF_VALUE), AW'(OFF_DIR), AW'(OFF_IRQ_EN),
                               AW'(OFF_SEL_A), AW'(OFF_SEL_B), AW'(OFF_SEL_C),
                               AW'(OFF_STATUS), AW'(OFF_LATCH)};

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && status == '0 && !irq));

  a_r2_latch_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFF_VALUE)) |=> pin_out == $past(wdata));

  a_r2_latch_ro: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFF_LATCH)) |=> $stable(pin_out));

  a_r4_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(OFF_DIR)) |=> pin_oe == $past(wdata));

  a_r3_value_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == AW'(OFF_VALUE)) |=> rdata == $past(smp));

  a_r8_level_sets: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(sel_b) & ~($past(smp) ^ $past(sel_a)) & ~status) == '0));

  a_r9_edge_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status) & ~$past(sel_b) & ~$past(clr_mask) & ~status) == '0));

  a_r10_irq_combine: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == |($past(status) & $past(irq_en)));

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .smp(smp), .status(status), .irq_en(irq_en),
  .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pins(logic [31:0] v);
    @(negedge clk); pin_in = v;
    settle();
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1 register", 8'(a*4), 32'h0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_latch();
    wr(8'h00, 32'hA5A5_0F0F);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    rd_chk("R2 readback", 8'h1C, 32'hA5A5_0F0F);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R2 readback ignores write", 8'h1C, 32'hA5A5_0F0F);
    chk("R2 pin_out after ro write", pin_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_dir();
    wr(8'h04, 32'h0000_FFFF);
    chk("R4 pin_oe", pin_oe, 32'h0000_FFFF);
    rd_chk("R4 dir read", 8'h04, 32'h0000_FFFF);
  endtask

  task automatic t_value();
    logic [31:0] d;
    @(negedge clk); pin_in = 32'h1234_5678; rd_en = 1; addr = 8'h00;
    @(negedge clk); rd_en = 0; d = rdata;
    chk("R3 sync delay", d, 32'h0);
    settle();
    rd_chk("R3 value is input not latch", 8'h00, 32'h1234_5678);
    pins(32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk("R9 clear all", 8'h18, 32'h0);
  endtask

  task automatic t_rise();
    wr(8'h0C, 32'h1);
    pins(32'h1);
    rd_chk("R5 rise sets", 8'h18, 32'h1);
    wr(8'h18, 32'h1);
    pins(32'h0);
    rd_chk("R5 fall ignored", 8'h18, 32'h0);
  endtask

  task automatic t_fall();
    pins(32'h2);
    rd_chk("R6 rise ignored", 8'h18, 32'h0);
    pins(32'h0);
    rd_chk("R6 fall sets", 8'h18, 32'h2);
    wr(8'h18, 32'h2);
  endtask

  task automatic t_both();
    wr(8'h14, 32'h4);
    pins(32'h4);
    rd_chk("R7 rise sets", 8'h18, 32'h4);
    wr(8'h18, 32'h4);
    pins(32'h0);
    rd_chk("R7 fall sets", 8'h18, 32'h4);
    wr(8'h18, 32'h4);
    rd_chk("R9 cleared", 8'h18, 32'h0);
  endtask

  task automatic t_level();
    wr(8'h0C, 32'h9);
    wr(8'h10, 32'h18);
    settle();
    rd_chk("R8 active low sets", 8'h18, 32'h10);
    pins(32'h8);
    rd_chk("R8 active high sets", 8'h18, 32'h18);
    wr(8'h18, 32'h8);
    rd_chk("R8 clear while active", 8'h18, 32'h18);
    pins(32'h0);
    wr(8'h18, 32'h8);
    rd_chk("R8 clear after inactive", 8'h18, 32'h10);
    pins(32'h10);
    wr(8'h18, 32'h10);
    rd_chk("R8 low level released", 8'h18, 32'h0);
  endtask

  task automatic t_irq();
    wr(8'h08, 32'h4);
    chk("R10 idle", {31'b0, irq}, 0);
    pins(32'h14);
    chk("R10 enabled pin raises", {31'b0, irq}, 1);
    wr(8'h18, 32'h4);
    repeat (2) @(negedge clk);
    chk("R10 cleared drops", {31'b0, irq}, 0);
    pins(32'h16);
    pins(32'h14);
    rd_chk("R10 status while disabled", 8'h18, 32'h2);
    chk("R10 masked", {31'b0, irq}, 0);
    wr(8'h08, 32'h6);
    repeat (2) @(negedge clk);
    chk("R10 enable late", {31'b0, irq}, 1);
  endtask

  task automatic t_w1c();
    pins(32'h10);
    rd_chk("R9 two pending", 8'h18, 32'h6);
    wr(8'h18, 32'h2);
    rd_chk("R9 zero bits kept", 8'h18, 32'h4);
    wr(8'h18, 32'h0);
    rd_chk("R9 zero write no effect", 8'h18, 32'h4);
  endtask

  task automatic t_unmapped();
    rd_chk("R11 unmapped 0x20", 8'h20, 32'h0);
    rd_chk("R11 misaligned", 8'h05, 32'h0);
    rd_chk("R11 mapped after", 8'h08, 32'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_latch();
    t_dir();
    t_value();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_irq();
    t_w1c();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule